// File: doc/BRIEF.md
# Lane-Partitioned Fixed-Point Add/Subtract Unit

This block is a 64-bit fixed-point arithmetic unit. Its carry chain can be cut into independent lanes, so one operation performs eight byte, four 16-bit, two 32-bit or one 64-bit addition or subtraction. A paired operation takes the same two sources and returns their sum on one result port and their difference on a second result port. A flag-setting copy, a silent copy and the bitwise AND, OR and XOR operations complete the set. Operands and controls are presented together and sampled on one clock edge. Both results and the flags are registered, so they appear one cycle later.

The condition flags are zero, negative, carry and overflow. They describe the most significant active lane, which is the lane that holds bit 63. A sticky overflow flag records an overflow in any lane of any result since reset. A saturation control can be set per operation. When it is set, a lane that overflows takes its signed limit instead of wrapping around.

Top module: `simd_alu`

## Requirements
- R1: `lane_i` selects the lane width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). With `op_i` = 0 (ADD), each lane of `res0_o` is the modulo sum of the matching lanes of `a_i` and `b_i`, and no carry crosses a lane boundary.
- R2: With `op_i` = 1 (SUB), each lane of `res0_o` is the modulo difference a − b of the matching lanes, and no borrow crosses a lane boundary.
- R3: With `op_i` = 2 (ADDSUB), `res0_o` carries the lane-wise a + b and `res1_o` carries the lane-wise a − b. Both come from the same sampled operands and appear in the same cycle.
- R4: Results appear one clock after the inputs are sampled. For every operation except ADDSUB, `res1_o` is zero.
- R5: With `op_i` = 3 (PASS), `res0_o` equals `a_i`. Zero and negative are taken from the top lane of `a_i` at the selected width, and carry and overflow are cleared.
- R6: With `op_i` = 4 (MOVE), `res0_o` equals `a_i`, and all five flags keep their previous values.
- R7: `op_i` = 5, 6 and 7 give the bitwise AND, OR and XOR of the full 64 bits. Zero and negative are taken from the top lane, with the width raised to at least 32 bits. Carry and overflow are cleared.
- R8: After ADD, SUB or ADDSUB, zero and negative describe `res0_o` in the top lane (bits 63 down). Carry is the carry out of that lane for an add, and for a subtract it is 1 exactly when no borrow occurs (a ≥ b unsigned). Overflow is the signed overflow of that lane.
- R9: `flag_sv_o` is set when any lane of `res0_o` overflows, or any lane of `res1_o` overflows in ADDSUB. Only reset clears it.
- R10: With `sat_i` = 1, an overflowing lane of an arithmetic result becomes its signed maximum (0x7F…F) if the lane of `a_i` is non-negative, and otherwise its signed minimum (0x80…0). The overflow flags still report the overflow.
- R11: While `rst_n` is low at a clock edge, both results and all flags become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code (0 ADD … 7 XOR) |
| lane_i | input | 2 | Lane width code |
| sat_i | input | 1 | Saturate overflowing lanes |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| res0_o | output | 64 | Primary result (sum in ADDSUB) |
| res1_o | output | 64 | Difference in ADDSUB, else zero |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_c_o | output | 1 | Carry / no-borrow flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_sv_o | output | 1 | Sticky overflow flag |

## Verification
The bound checker watches these properties on every cycle:
- MOVE leaves every flag untouched.
- The sticky flag never falls and is set whenever overflow is shown.
- PASS and the logical operations clear carry and overflow.
- The second result stays zero outside ADDSUB.
- For an unsaturated 64-bit ADDSUB, the two results sum to twice the first operand.

Lane isolation, per-lane carry and borrow, saturation limits and flag extraction at each width can only be shown by the bench. It drives directed boundary operands and long random runs, and compares them against its lane-by-lane model.

// File: rtl/simd_alu_pkg.sv
// Shared types for the lane-partitioned add/subtract unit.
package simd_alu_pkg;
    localparam int DATA_W  = 64;
    localparam int SLICE_W = 8;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_ADDSUB = 3'd2,
        OP_PASS   = 3'd3,
        OP_MOVE   = 3'd4,
        OP_AND    = 3'd5,
        OP_OR     = 3'd6,
        OP_XOR    = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;
endpackage

// File: rtl/simd_lane_addsub.sv
// Lane-partitioned adder/subtractor built from byte slices.
// The carry restarts at every lane start. Per-lane carry and overflow are
// reported at the lane's top slice, and optional saturation is applied.
// Assumes lane width code lw selects 2**lw slices per lane, at most NS.
module simd_lane_addsub #(
    parameter int DW = 64,
    parameter int SW = 8,
    parameter int LWW = 2
) (
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             sub,
    input  logic             sat,
    input  logic [LWW-1:0]   lw,
    output logic [DW-1:0]    res,
    output logic [DW/SW-1:0] end_c,
    output logic [DW/SW-1:0] end_v
);
    localparam int NS = DW / SW;
    localparam logic [SW-1:0] TOP_MAX = {1'b0, {(SW-1){1'b1}}};
    localparam logic [SW-1:0] TOP_MIN = {1'b1, {(SW-1){1'b0}}};

    int            lb;
    logic [DW-1:0] raw;

    // slices per lane
    assign lb = 1 << lw;

    // ripple across slices, restarting the carry at each lane start
    always_comb begin
        logic          cy;
        logic [SW:0]   t;
        logic [SW-1:0] bx;
        raw   = '0;
        end_c = '0;
        end_v = '0;
        cy    = sub;
        t     = '0;
        for (int k = 0; k < NS; k++) begin
            if ((k & (lb - 1)) == 0) cy = sub;
            bx = b[k*SW +: SW] ^ {SW{sub}};
            t  = {1'b0, a[k*SW +: SW]} + {1'b0, bx} + {{SW{1'b0}}, cy};
            raw[k*SW +: SW] = t[SW-1:0];
            if ((k & (lb - 1)) == lb - 1) begin
                end_c[k] = t[SW];
                end_v[k] = (a[k*SW+SW-1] == bx[SW-1]) && (t[SW-1] != a[k*SW+SW-1]);
            end
            cy = t[SW];
        end
    end

    // replace overflowing lanes with their signed limit when saturating
    always_comb begin
        res = raw;
        for (int k = 0; k < NS; k++) begin
            int e;
            e = k | (lb - 1);
            if (sat && end_v[e]) begin
                if (a[e*SW+SW-1])
                    res[k*SW +: SW] = (k == e) ? TOP_MIN : '0;
                else
                    res[k*SW +: SW] = (k == e) ? TOP_MAX : '1;
            end
        end
    end
endmodule

// File: rtl/simd_alu_flags.sv
// Condition flag extraction from the most significant active lane.
// Assumes the top lane spans SW << lw_eff bits ending at bit DW-1.
module simd_alu_flags
    import simd_alu_pkg::*;
#(
    parameter int DW = 64,
    parameter int SW = 8,
    parameter int LWW = 2
) (
    input  logic [DW-1:0]  val,
    input  logic [LWW-1:0] lw_eff,
    input  logic           arith,
    input  logic           top_c,
    input  logic           top_v,
    output alu_flags_t     flags
);
    logic [DW-1:0] hi_mask;

    // bits belonging to the top lane
    assign hi_mask = ~({DW{1'b1}} >> (SW << lw_eff));

    // flags: Z/N from the lane, C/V only for arithmetic
    always_comb begin
        flags.z = ((val & hi_mask) == '0);
        flags.n = val[DW-1];
        flags.c = arith & top_c;
        flags.v = arith & top_v;
    end
endmodule

// File: rtl/simd_alu.sv
// Top of the lane-partitioned fixed-point unit.
// Inputs are sampled every cycle, and results and flags are registered.
// One slice adder serves ADD/SUB and the sum of ADDSUB. A second one, fixed
// to subtract, gives the ADDSUB difference.
module simd_alu
    import simd_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  op_i,
    input  logic [1:0]  lane_i,
    input  logic        sat_i,
    input  logic [63:0] a_i,
    input  logic [63:0] b_i,
    output logic [63:0] res0_o,
    output logic [63:0] res1_o,
    output logic        flag_z_o,
    output logic        flag_n_o,
    output logic        flag_c_o,
    output logic        flag_v_o,
    output logic        flag_sv_o
);
    localparam int NS  = DATA_W / SLICE_W;
    localparam int LWW = 2;
    localparam logic [LWW-1:0] LW_LOGIC_MIN = 2'd2;

    alu_op_e         op;
    logic [63:0]     sum_res, dif_res, nxt_r0, nxt_r1, fsrc;
    logic [NS-1:0]   sum_c, sum_v, dif_c, dif_v;
    logic [LWW-1:0]  lw_eff;
    logic            arith, upd, ovf_any;
    logic            unused_dif_c;
    alu_flags_t      fl_nxt;

    assign op = alu_op_e'(op_i);
    assign unused_dif_c = ^dif_c;

    // primary lane adder: subtracts only for SUB
    simd_lane_addsub #(.DW(DATA_W), .SW(SLICE_W), .LWW(LWW)) u_sum (
        .a(a_i), .b(b_i), .sub(op == OP_SUB), .sat(sat_i), .lw(lane_i),
        .res(sum_res), .end_c(sum_c), .end_v(sum_v)
    );

    // secondary lane subtractor for the paired operation
    simd_lane_addsub #(.DW(DATA_W), .SW(SLICE_W), .LWW(LWW)) u_dif (
        .a(a_i), .b(b_i), .sub(1'b1), .sat(sat_i), .lw(lane_i),
        .res(dif_res), .end_c(dif_c), .end_v(dif_v)
    );

    // select results, flag source and flag update per operation
    always_comb begin
        nxt_r0 = a_i;
        nxt_r1 = '0;
        lw_eff = lane_i;
        arith  = 1'b0;
        upd    = 1'b1;
        unique case (op)
            OP_ADD, OP_SUB: begin
                nxt_r0 = sum_res;
                arith  = 1'b1;
            end
            OP_ADDSUB: begin
                nxt_r0 = sum_res;
                nxt_r1 = dif_res;
                arith  = 1'b1;
            end
            OP_PASS: ;
            OP_MOVE: upd = 1'b0;
            OP_AND: nxt_r0 = a_i & b_i;
            OP_OR:  nxt_r0 = a_i | b_i;
            OP_XOR: nxt_r0 = a_i ^ b_i;
            default: ;
        endcase
        if (op == OP_AND || op == OP_OR || op == OP_XOR)
            lw_eff = (lane_i < LW_LOGIC_MIN) ? LW_LOGIC_MIN : lane_i;
        fsrc = nxt_r0;
    end

    // any lane overflow of a produced arithmetic result
    assign ovf_any = arith && ((|sum_v) || (op == OP_ADDSUB && (|dif_v)));

    simd_alu_flags #(.DW(DATA_W), .SW(SLICE_W), .LWW(LWW)) u_flags (
        .val(fsrc), .lw_eff(lw_eff), .arith(arith),
        .top_c(sum_c[NS-1]), .top_v(sum_v[NS-1]), .flags(fl_nxt)
    );

    // result and flag registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res0_o    <= '0;
            res1_o    <= '0;
            flag_z_o  <= 1'b0;
            flag_n_o  <= 1'b0;
            flag_c_o  <= 1'b0;
            flag_v_o  <= 1'b0;
            flag_sv_o <= 1'b0;
        end else begin
            res0_o <= nxt_r0;
            res1_o <= nxt_r1;
            if (upd) begin
                flag_z_o <= fl_nxt.z;
                flag_n_o <= fl_nxt.n;
                flag_c_o <= fl_nxt.c;
                flag_v_o <= fl_nxt.v;
            end
            flag_sv_o <= flag_sv_o | ovf_any;
        end
    end
endmodule

// File: rtl/simd_alu_chk.sv
// Protocol checker for simd_alu, bound to every instance.
// It watches only ports and relates them across one clock.
module simd_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_i,
    input logic [1:0]  lane_i,
    input logic        sat_i,
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic [63:0] res0_o,
    input logic [63:0] res1_o,
    input logic        flag_z_o,
    input logic        flag_n_o,
    input logic        flag_c_o,
    input logic        flag_v_o,
    input logic        flag_sv_o
);
    // R11: reset clears results and flags
    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (res0_o == '0 && res1_o == '0 &&
                    {flag_z_o, flag_n_o, flag_c_o, flag_v_o, flag_sv_o} == '0));

    // R6: MOVE keeps all flags
    a_r6_move_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> $stable({flag_z_o, flag_n_o, flag_c_o, flag_v_o, flag_sv_o}));

    // R9: sticky overflow never falls outside reset
    a_r9_sticky_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(flag_sv_o));

    // R9: reported overflow always leaves the sticky flag set
    a_r9_v_implies_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v_o |-> flag_sv_o);

    // R5: PASS copies the operand and clears C/V
    a_r5_pass_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> (res0_o == $past(a_i) && !flag_c_o && !flag_v_o));

    // R7: logical operations clear C/V; AND is bitwise
    a_r7_logic_no_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 3'd5) |=> (!flag_c_o && !flag_v_o));
    a_r7_and_bitwise: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |=> (res0_o == ($past(a_i) & $past(b_i))));

    // R4: second result is zero outside ADDSUB
    a_r4_res1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd2) |=> (res1_o == '0));

    // R3: unsaturated 64-bit pair: sum plus difference equals 2a
    a_r3_pair_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && lane_i == 2'd3 && !sat_i) |=>
            ((res0_o + res1_o) == ($past(a_i) << 1)));
endmodule

bind simd_alu simd_alu_chk u_chk (.*);

// File: tb/simd_alu_tb_top.sv
`timescale 1ns/1ps
module simd_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  lane_i = '0;
    logic        sat_i = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [63:0] res0_o, res1_o;
    logic        flag_z_o, flag_n_o, flag_c_o, flag_v_o, flag_sv_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] cur_fl = '0;   // {z,n,c,v,sv} expected state

    always #2.5 clk = ~clk;

    simd_alu dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one lane behaviourally with wide signed integers
    function automatic void lane_op(input logic [63:0] av, input logic [63:0] bv, input int w,
                                    input bit sub, input bit s,
                                    output logic [63:0] rv, output bit c, output bit v);
        logic signed [67:0] sa, sb, t, mx, mn;
        logic [67:0] m, us;
        m  = (68'd1 << w) - 68'd1;
        sa = {4'b0, av};
        if (av[w-1]) sa = sa - (68'sd1 <<< w);
        sb = {4'b0, bv};
        if (bv[w-1]) sb = sb - (68'sd1 <<< w);
        t  = sub ? sa - sb : sa + sb;
        mx = (68'sd1 <<< (w - 1)) - 68'sd1;
        mn = -(68'sd1 <<< (w - 1));
        v  = (t > mx) || (t < mn);
        us = {4'b0, av} + {4'b0, bv};
        c  = sub ? (av >= bv) : (us > m);
        if (s && v) t = (t > mx) ? mx : mn;
        rv = t[63:0] & m[63:0];
    endfunction

    function automatic void model(input logic [2:0] op, input logic [1:0] lw, input bit s,
                                  input logic [63:0] a, input logic [63:0] b, input logic [4:0] fin,
                                  output logic [63:0] r0, output logic [63:0] r1, output logic [4:0] fo);
        int w;
        logic [63:0] m, av, bv, rv;
        bit c, v, ct, vt, anyv;
        w = 8 << lw;
        r1 = '0;
        fo = fin;
        if (op == 3'd4) begin
            r0 = a;
        end else if (op == 3'd3 || op >= 3'd5) begin
            if (op >= 3'd5 && w < 32) w = 32;
            case (op)
                3'd5: r0 = a & b;
                3'd6: r0 = a | b;
                3'd7: r0 = a ^ b;
                default: r0 = a;
            endcase
            fo = {((r0 >> (64 - w)) == 0), r0[63], 1'b0, 1'b0, fin[0]};
        end else begin
            m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            r0 = '0;
            anyv = 0;
            ct = 0;
            vt = 0;
            for (int i = 0; i < 64 / w; i++) begin
                av = (a >> (i * w)) & m;
                bv = (b >> (i * w)) & m;
                lane_op(av, bv, w, op == 3'd1, s, rv, c, v);
                r0 |= rv << (i * w);
                anyv |= v;
                if (i == 64 / w - 1) begin ct = c; vt = v; end
                if (op == 3'd2) begin
                    lane_op(av, bv, w, 1'b1, s, rv, c, v);
                    r1 |= rv << (i * w);
                    anyv |= v;
                end
            end
            fo = {((r0 >> (64 - w)) == 0), r0[63], ct, vt, fin[0] | anyv};
        end
    endfunction

    // drive one operation at a falling edge; compare after the next rising edge
    task automatic step(input logic [2:0] op, input logic [1:0] lw, input bit s,
                        input logic [63:0] a, input logic [63:0] b);
        logic [63:0] e0, e1;
        logic [4:0]  ef, af;
        string t0, t1, tf;
        model(op, lw, s, a, b, cur_fl, e0, e1, ef);
        op_i = op; lane_i = lw; sat_i = s; a_i = a; b_i = b;
        @(negedge clk);
        case (op)
            3'd0: t0 = "R1 add";
            3'd1: t0 = "R2 sub";
            3'd2: t0 = "R3 pair sum";
            3'd3: t0 = "R5 pass";
            3'd4: t0 = "R6 move";
            default: t0 = "R7 logic";
        endcase
        if (s && op <= 3'd2) t0 = {t0, " R10 sat"};
        t1 = (op == 3'd2) ? "R3 pair diff" : "R4 res1 zero";
        tf = (op == 3'd4) ? "R6 flags" : (op == 3'd3) ? "R5 flags" :
             (op >= 3'd5) ? "R7 flags" : "R8 flags";
        af = {flag_z_o, flag_n_o, flag_c_o, flag_v_o, flag_sv_o};
        chk(res0_o === e0, t0, res0_o, e0);
        chk(res1_o === e1, t1, res1_o, e1);
        chk(af[4:1] === ef[4:1], tf, {60'd0, af[4:1]}, {60'd0, ef[4:1]});
        chk(af[0] === ef[0], "R9 sticky", {63'd0, af[0]}, {63'd0, ef[0]});
        cur_fl = ef;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_i = 3'd2; a_i = 64'h1234; b_i = 64'h5678;
        @(negedge clk);
        @(negedge clk);
        chk(res0_o === '0 && res1_o === '0, "R11 reset results", res0_o | res1_o, 64'd0);
        chk({flag_z_o, flag_n_o, flag_c_o, flag_v_o, flag_sv_o} === 5'd0, "R11 reset flags",
            {59'd0, flag_z_o, flag_n_o, flag_c_o, flag_v_o, flag_sv_o}, 64'd0);
        cur_fl = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: byte lanes of 0xFF + 1 wrap to zero with no carry across lanes
        step(3'd0, 2'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
        // R1: 16-bit lanes
        step(3'd0, 2'd1, 0, 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000);
        // R1: full 64-bit carry chain
        step(3'd0, 2'd3, 0, 64'h0000_0000_FFFF_FFFF, 64'h1);
        // R2: borrow stays inside each 32-bit lane
        step(3'd1, 2'd2, 0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
        // R10: saturate positive and negative byte overflow
        step(3'd0, 2'd0, 1, 64'h7F80_7F80_0000_0000, 64'h0180_0101_0000_0000);
        step(3'd1, 2'd1, 1, 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_0000_0003);
        // R3: paired add/sub at 16 bits
        step(3'd2, 2'd1, 0, 64'h0010_0020_0030_0040, 64'h0001_0002_0003_0050);
        // R9: sticky holds through quiet operations; R6 flags held by MOVE
        step(3'd4, 2'd0, 0, 64'hDEAD_BEEF_0000_0001, 64'h0);
        step(3'd0, 2'd3, 0, 64'h1, 64'h1);
        // R5: pass of zero top lane, R7 logic at narrow lane code
        step(3'd3, 2'd0, 0, 64'h00FF_FFFF_FFFF_FFFF, 64'h0);
        step(3'd5, 2'd0, 0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF);
        step(3'd6, 2'd1, 0, 64'h8000_0000_0000_0000, 64'h1);
        step(3'd7, 2'd3, 0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA);
        // random operands across every operation, lane width and saturation setting
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (($urandom % 8) == 0) rb = ~ra;
            if (($urandom % 8) == 1) rb = ra;
            step(3'($urandom % 8), 2'($urandom % 4), 1'($urandom % 2), ra, rb);
            if (i == 2000) do_reset();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule